// File: doc/BRIEF.md
# Indexed Codec Control Register Front End

This block is the bus-facing register file of an audio codec. A processor reaches it through a 64-byte window of sixteen 32-bit words on a simple synchronous bus: an address, a write enable, write data, and read data that is driven combinationally. Most words are plain storage. One word holds a 5-bit pointer and another acts as a data port, so a small direct window reaches thirty-two 8-bit indirect codec registers.

Some indirect entries have special access rules. One entry can be written but reads back as zero. Two entries cannot be written. One entry keeps only a single writable bit and has a hardwired identification pattern in its other bits. On the direct side, one word reads as zero at all times. The control word holds a bit that clears the whole register file, and the control word still keeps its own new value after that clear. The interrupt output exists for integration and stays low.

Top module: `codec_regif`

## Requirements
- R1: The word index is the byte address shifted right by two, so the low two address bits are ignored. A write to any word other than 1, 2 and 4 stores all 32 bits, and a read of that word returns the stored value.
- R2: The low five bits of word 0 select one of 32 indirect entries. A read of word 1 returns the selected entry, zero-extended to 32 bits. The upper bits of word 0 are stored in full but do not affect the selection.
- R3: A write to word 1 stores the low 8 bits of the write data into the selected indirect entry. It does not change word 0.
- R4: Indirect entry 3 is write-only. A read of it through word 1 returns zero, even after a write.
- R5: Indirect entries 11 and 25 are read-only. Writes to them through word 1 leave their values unchanged: 0x00 for entry 11 and 0xA0 for entry 25.
- R6: A write to indirect entry 12 stores (data AND 0x40) OR 0x8A. The result is 0xCA when bit 6 is set and 0x8A when it is clear.
- R7: After the active-low asynchronous reset, every direct word and indirect entry reads zero, except entry 12, which reads 0x8A, and entry 25, which reads 0xA0.
- R8: Word 2 always reads zero, and writes to it are discarded.
- R9: A write to word 4 with bit 0 set returns every register to the R7 values in that same clock edge. Word 4 then holds the written value masked to bits 6:0.
- R10: A write to word 4 with bit 0 clear stores the value masked to bits 6:0 and changes no other register.
- R11: The interrupt output is always 0.
- R12: Read data follows the address combinationally. A write becomes visible only after the rising clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and the soft clear act on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address within the window |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_o | output | 1 | Interrupt request, held low |

## Verification
The assertions check these rules on every cycle: the interrupt stays low, word 2 and entry 3 read as zero, the identification bits of entries 12 and 25 hold their fixed values, the soft clear resets the pointer, the control word keeps its seven masked bits, and a data-port write lands in the selected entry. Some behaviour can only be shown by the bench's scenarios, because it depends on a sequence of accesses. This covers address aliasing through the low address bits, the pointer ignoring the upper bits of word 0, the control word retaining plain storage when bit 0 is clear, the complete clear of every other register after a soft clear, and read data that shows the old value until the clock edge.

// File: rtl/codec_regif_pkg.sv
package codec_regif_pkg;

  // Direct word numbers whose behaviour is special
  localparam int unsigned WORD_INDEX = 0;
  localparam int unsigned WORD_DATA  = 1;
  localparam int unsigned WORD_FIXED = 2;
  localparam int unsigned WORD_CTRL  = 4;

  // Indirect entries with special access
  localparam int unsigned ENT_WO      = 3;
  localparam int unsigned ENT_RO_ZERO = 11;
  localparam int unsigned ENT_MIX     = 12;
  localparam int unsigned ENT_RO_ID   = 25;

  localparam logic [7:0] CODEC_ID = 8'h8A;
  localparam logic [7:0] CHIP_ID  = 8'hA0;
  localparam logic [7:0] MIX_KEEP = 8'h40;

  // Bits of the control word that are retained
  localparam int unsigned CTRL_KEEP_W = 7;

  typedef enum logic [1:0] {
    ACC_PLAIN,
    ACC_RO,
    ACC_WO,
    ACC_MIX
  } acc_kind_e;

  function automatic acc_kind_e entry_kind(input int unsigned idx);
    if (idx == ENT_RO_ZERO || idx == ENT_RO_ID) return ACC_RO;
    if (idx == ENT_WO) return ACC_WO;
    if (idx == ENT_MIX) return ACC_MIX;
    return ACC_PLAIN;
  endfunction

  function automatic logic [7:0] entry_init(input int unsigned idx);
    if (idx == ENT_MIX) return CODEC_ID;
    if (idx == ENT_RO_ID) return CHIP_ID;
    return 8'h00;
  endfunction

  function automatic logic [7:0] mix_store(input logic [7:0] w);
    return (w & MIX_KEEP) | CODEC_ID;
  endfunction

endpackage

// File: rtl/codec_regif_decode.sv
module codec_regif_decode
  import codec_regif_pkg::*;
#(
  parameter int unsigned N_WORDS = 16,
  localparam int unsigned WORD_W = $clog2(N_WORDS)
) (
  input  logic              bus_we,
  input  logic [WORD_W-1:0] word,
  input  logic              ctrl_bit0,
  output logic [N_WORDS-1:0] word_we,
  output logic              ent_we,
  output logic              soft_rst
);

  for (genvar i = 0; i < N_WORDS; i++) begin : g_we
    assign word_we[i] = bus_we && (word == WORD_W'(i));
  end

  assign ent_we   = bus_we && (word == WORD_W'(WORD_DATA));
  assign soft_rst = bus_we && (word == WORD_W'(WORD_CTRL)) && ctrl_bit0;

endmodule

// File: rtl/codec_direct_bank.sv
module codec_direct_bank
  import codec_regif_pkg::*;
#(
  parameter int unsigned N_WORDS = 16,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            soft_rst,
  input  logic [N_WORDS-1:0]              word_we,
  input  logic [DATA_W-1:0]               wdata,
  output logic [N_WORDS-1:0][DATA_W-1:0]  words
);

  for (genvar i = 0; i < N_WORDS; i++) begin : g_word
    if (i == WORD_DATA || i == WORD_FIXED) begin : g_none
      // word 1 is the data port and word 2 is fixed; neither holds storage
      assign words[i] = '0;
    end else if (i == WORD_CTRL) begin : g_ctrl
      logic [CTRL_KEEP_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          q <= '0;
        else if (word_we[i]) q <= wdata[CTRL_KEEP_W-1:0];
      end
      assign words[i] = DATA_W'(q);
    end else begin : g_plain
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          q <= '0;
        else if (soft_rst)   q <= '0;
        else if (word_we[i]) q <= wdata;
      end
      assign words[i] = q;
    end
  end

endmodule

// File: rtl/codec_indirect_bank.sv
module codec_indirect_bank
  import codec_regif_pkg::*;
#(
  parameter int unsigned N_ENT = 32,
  parameter int unsigned IND_W = 8,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          soft_rst,
  input  logic                          ent_we,
  input  logic [IDX_W-1:0]              idx,
  input  logic [IND_W-1:0]              wbyte,
  output logic [IND_W-1:0]              rd_byte,
  output logic [N_ENT-1:0][IND_W-1:0]   entries
);

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    localparam acc_kind_e KIND = entry_kind(i);
    localparam logic [IND_W-1:0] INIT = IND_W'(entry_init(i));
    logic [IND_W-1:0] q;
    logic hit;
    assign hit = ent_we && (idx == IDX_W'(i));

    if (KIND == ACC_RO) begin : g_ro
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= INIT;
        else if (soft_rst) q <= INIT;
      end
    end else if (KIND == ACC_MIX) begin : g_mix
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= INIT;
        else if (soft_rst) q <= INIT;
        else if (hit)      q <= IND_W'(mix_store(wbyte[7:0]));
      end
    end else begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= INIT;
        else if (soft_rst) q <= INIT;
        else if (hit)      q <= wbyte;
      end
    end
    assign entries[i] = q;
  end

  always_comb begin
    if (entry_kind(32'(idx)) == ACC_WO) rd_byte = '0;
    else                                rd_byte = entries[idx];
  end

endmodule

// File: rtl/codec_regif.sv
module codec_regif
  import codec_regif_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 64,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned N_ENT     = 32,
  parameter int unsigned IND_W     = 8,
  localparam int unsigned ADDR_W   = $clog2(WIN_BYTES),
  localparam int unsigned N_WORDS  = WIN_BYTES / 4,
  localparam int unsigned WORD_W   = $clog2(N_WORDS),
  localparam int unsigned IDX_W    = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);

  logic [WORD_W-1:0]               word;
  logic [N_WORDS-1:0]              word_we;
  logic                            ent_we;
  logic                            soft_rst;
  logic [N_WORDS-1:0][DATA_W-1:0]  words;
  logic [N_ENT-1:0][IND_W-1:0]     entries;
  logic [IDX_W-1:0]                cur_idx;
  logic [IND_W-1:0]                ent_rd;
  // named views for the checker
  logic [DATA_W-1:0]               ctrl_word;
  logic [IND_W-1:0]                ent_mix;
  logic [IND_W-1:0]                ent_id;

  assign word    = bus_addr[ADDR_W-1:2];
  assign cur_idx = words[WORD_INDEX][IDX_W-1:0];

  codec_regif_decode #(.N_WORDS(N_WORDS)) u_dec (
    .bus_we   (bus_we),
    .word     (word),
    .ctrl_bit0(bus_wdata[0]),
    .word_we  (word_we),
    .ent_we   (ent_we),
    .soft_rst (soft_rst)
  );

  codec_direct_bank #(.N_WORDS(N_WORDS), .DATA_W(DATA_W)) u_dir (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst),
    .word_we (word_we),
    .wdata   (bus_wdata),
    .words   (words)
  );

  codec_indirect_bank #(.N_ENT(N_ENT), .IND_W(IND_W)) u_ind (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst),
    .ent_we  (ent_we),
    .idx     (cur_idx),
    .wbyte   (bus_wdata[IND_W-1:0]),
    .rd_byte (ent_rd),
    .entries (entries)
  );

  assign ctrl_word = words[WORD_CTRL];
  assign ent_mix   = entries[ENT_MIX];
  assign ent_id    = entries[ENT_RO_ID];

  always_comb begin
    if (word == WORD_W'(WORD_DATA)) bus_rdata = DATA_W'(ent_rd);
    else                            bus_rdata = words[word];
  end

  assign irq_o = 1'b0;

endmodule

// File: rtl/codec_regif_chk.sv
module codec_regif_chk
  import codec_regif_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IND_W  = 8,
  parameter int unsigned IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_o,
  input logic              soft_rst,
  input logic [IDX_W-1:0]  cur_idx,
  input logic [IND_W-1:0]  ent_rd,
  input logic [DATA_W-1:0] ctrl_word,
  input logic [IND_W-1:0]  ent_mix,
  input logic [IND_W-1:0]  ent_id
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  logic [WORD_W-1:0] word;
  logic plain_ent;
  assign word = bus_addr[ADDR_W-1:2];
  assign plain_ent = entry_kind(32'(cur_idx)) == ACC_PLAIN;

  always_comb begin
    if (rst_n) a_r11_irq_low: assert (irq_o == 1'b0);
  end

  a_r8_fixed_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (word == WORD_W'(WORD_FIXED)) |-> (bus_rdata == '0));

  a_r4_wo_entry_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (word == WORD_W'(WORD_DATA) && cur_idx == IDX_W'(ENT_WO)) |-> (bus_rdata == '0));

  a_r5_id_entry_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    ent_id == IND_W'(CHIP_ID));

  a_r6_mix_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_mix & ~IND_W'(MIX_KEEP)) == IND_W'(CODEC_ID));

  a_r9_soft_clear_index: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cur_idx == '0));

  a_r9_ctrl_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && word == WORD_W'(WORD_CTRL)) |=>
      (ctrl_word == DATA_W'($past(bus_wdata[CTRL_KEEP_W-1:0]))));

  a_r3_port_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && word == WORD_W'(WORD_DATA) && plain_ent) |=>
      (ent_rd == $past(bus_wdata[IND_W-1:0])));

  a_r6_mix_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && word == WORD_W'(WORD_DATA) && cur_idx == IDX_W'(ENT_MIX)) |=>
      (ent_rd == IND_W'(mix_store($past(bus_wdata[7:0])))));

endmodule

bind codec_regif codec_regif_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IND_W(IND_W), .IDX_W(IDX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .irq_o    (irq_o),
  .soft_rst (soft_rst),
  .cur_idx  (cur_idx),
  .ent_rd   (ent_rd),
  .ctrl_word(ctrl_word),
  .ent_mix  (ent_mix),
  .ent_id   (ent_id)
);

// File: tb/codec_regif_tb.sv
`timescale 1ns/1ps
module codec_regif_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  codec_regif u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic rd_ent(input int unsigned e, output logic [31:0] d);
    wr(6'h00, 32'(e));
    rd(6'h04, d);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    rd(6'h00, v);  check("R7 word0 after reset", v, 32'h0);
    rd(6'h14, v);  check("R7 word5 after reset", v, 32'h0);
    rd(6'h10, v);  check("R7 word4 after reset", v, 32'h0);
    rd_ent(12, v); check("R7 entry12 after reset", v, 32'h8A);
    rd_ent(25, v); check("R7 entry25 after reset", v, 32'hA0);
    rd_ent(7, v);  check("R7 entry7 after reset", v, 32'h0);
    check("R11 irq low", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_direct_words();
    logic [31:0] v;
    wr(6'h14, 32'hDEADBEEF);
    rd(6'h14, v);  check("R1 word5 readback", v, 32'hDEADBEEF);
    rd(6'h17, v);  check("R1 low addr bits ignored", v, 32'hDEADBEEF);
    wr(6'h3E, 32'h12345678);
    rd(6'h3C, v);  check("R1 word15 aliased write", v, 32'h12345678);
    wr(6'h0C, 32'hCAFEF00D);
    rd(6'h0C, v);  check("R1 word3 readback", v, 32'hCAFEF00D);
  endtask

  task automatic t_fixed_word();
    logic [31:0] v;
    wr(6'h08, 32'hFFFFFFFF);
    rd(6'h08, v);  check("R8 word2 reads zero", v, 32'h0);
  endtask

  task automatic t_indirect_rw();
    logic [31:0] v;
    wr(6'h00, 32'd7);
    wr(6'h04, 32'h000001A5);
    rd(6'h04, v);  check("R2 entry7 zero-extended", v, 32'hA5);
    rd(6'h00, v);  check("R3 word0 unchanged by port write", v, 32'd7);
    wr(6'h00, 32'hFFFFFFE9);
    wr(6'h04, 32'h3C);
    rd(6'h00, v);  check("R2 word0 stores full value", v, 32'hFFFFFFE9);
    wr(6'h00, 32'h29);
    rd(6'h04, v);  check("R2 index uses low five bits", v, 32'h3C);
    rd_ent(7, v);  check("R3 entry7 kept", v, 32'hA5);
  endtask

  task automatic t_write_only();
    logic [31:0] v;
    wr(6'h00, 32'd3);
    wr(6'h04, 32'h77);
    rd(6'h04, v);  check("R4 entry3 reads zero", v, 32'h0);
  endtask

  task automatic t_read_only();
    logic [31:0] v;
    wr(6'h00, 32'd11);
    wr(6'h04, 32'h55);
    rd(6'h04, v);  check("R5 entry11 unchanged", v, 32'h0);
    wr(6'h00, 32'd25);
    wr(6'h04, 32'h55);
    rd(6'h04, v);  check("R5 entry25 unchanged", v, 32'hA0);
  endtask

  task automatic t_mix_entry();
    logic [31:0] v;
    wr(6'h00, 32'd12);
    wr(6'h04, 32'hFF);
    rd(6'h04, v);  check("R6 entry12 all ones", v, 32'hCA);
    wr(6'h04, 32'h00);
    rd(6'h04, v);  check("R6 entry12 zero", v, 32'h8A);
    wr(6'h04, 32'h40);
    rd(6'h04, v);  check("R6 entry12 bit6", v, 32'hCA);
  endtask

  task automatic t_ctrl_plain();
    logic [31:0] v;
    wr(6'h14, 32'h0000BEEF);
    wr(6'h10, 32'hFFFFFFFE);
    rd(6'h10, v);  check("R10 word4 masked", v, 32'h7E);
    rd(6'h14, v);  check("R10 word5 kept", v, 32'h0000BEEF);
    rd_ent(12, v); check("R10 entry12 kept", v, 32'hCA);
  endtask

  task automatic t_soft_clear();
    logic [31:0] v;
    wr(6'h14, 32'hAAAA5555);
    wr(6'h00, 32'd7);
    wr(6'h04, 32'h11);
    wr(6'h10, 32'h00000181);
    rd(6'h10, v);  check("R9 word4 after clear", v, 32'h01);
    rd(6'h14, v);  check("R9 word5 cleared", v, 32'h0);
    rd(6'h00, v);  check("R9 word0 cleared", v, 32'h0);
    rd_ent(7, v);  check("R9 entry7 cleared", v, 32'h0);
    rd_ent(12, v); check("R9 entry12 restored", v, 32'h8A);
    rd_ent(25, v); check("R9 entry25 restored", v, 32'hA0);
  endtask

  task automatic t_comb_read();
    logic [31:0] v;
    wr(6'h18, 32'h11112222);
    @(negedge clk);
    bus_addr = 6'h18; bus_we = 1'b1; bus_wdata = 32'h33334444;
    #1 check("R12 old value before edge", bus_rdata, 32'h11112222);
    @(negedge clk);
    bus_we = 1'b0;
    #1 check("R12 new value after edge", bus_rdata, 32'h33334444);
    bus_addr = 6'h14;
    #0.5 check("R12 follows address", bus_rdata, 32'h0);
  endtask

  task automatic t_async_reset();
    logic [31:0] v;
    wr(6'h10, 32'h3E);
    wr(6'h1C, 32'h5A5A5A5A);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #5 rst_n = 1'b1;
    rd(6'h10, v);  check("R7 word4 cleared by reset pin", v, 32'h0);
    rd(6'h1C, v);  check("R7 word7 cleared by reset pin", v, 32'h0);
    rd_ent(12, v); check("R7 entry12 after reset pin", v, 32'h8A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_direct_words();
    t_fixed_word();
    t_indirect_rw();
    t_write_only();
    t_read_only();
    t_mix_entry();
    t_ctrl_plain();
    t_soft_clear();
    t_comb_read();
    t_async_reset();
    check("R11 irq low at end", {31'b0, irq_o}, 32'h0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule